// File: doc/BRIEF.md
# Virtually Indexed, Physically Tagged Data Cache with Translation Buffer

The block is a direct-mapped data cache of 1024 words that is indexed with untranslated address bits while an eight-entry fully associative translation buffer maps the 20-bit page number to a 20-bit physical frame in the same cycle. Pages are 4 KB. The cache index (bits 11:2) and the byte offset (bits 1:0) both fall inside the page displacement. As a result the data array and the translation buffer are read side by side. The stored tag is the physical frame number and is compared against the buffer's output.

A requester hands over one load or store at a time through a valid/ready handshake. One of three things then happens. The block answers directly. Or, when the translation hits but the line misses, it asks the memory side for the word at the physical address and waits for the fill. Or, when the translation misses, it raises a translation request and waits until a refill is written through the refill port. After a fill or a refill the lookup is retried internally. Each translation entry carries read and write permission bits, a reference bit and a dirty bit. The response shows those two bits as they stood before the access.

Top module: `xlat_cache`

## Requirements
- R1: The virtual address splits into a page number (bits 31:12), a line index (bits 11:2) and an ignored byte offset (bits 1:0). The memory address on a miss is {frame, index, 2'b00}.
- R2: A request is accepted at a clock edge where req_valid and req_ready are both high. If the translation hits and the indexed line is valid with a tag equal to the frame, rsp_valid rises in the next cycle with rsp_hit=1 and the stored word on rsp_rdata.
- R3: On a translation miss, xlat_req stays high with xlat_vpn equal to the page number until a refill is written. The lookup is then retried.
- R4: On a translation hit with a line miss, mem_req stays high with a steady mem_paddr until mem_fill_valid. The fill writes the data, the frame tag and the valid bit into the line. The retried access then completes with rsp_hit=0 and returns the filled word.
- R5: The hit test compares the stored tag with the physical frame. Two pages that map to one frame share a line. Two different frames at one index evict each other.
- R6: A store that hits replaces the indexed word. Later loads return the new value.
- R7: The permission field tlb_wr_rights has bit 0 allowing loads and bit 1 allowing stores. An access that its entry forbids completes at once with rsp_fault=1 and rsp_hit=0. It issues no memory request and leaves the cache word unchanged.
- R8: rsp_ref reports the entry's reference bit before the access. Every non-faulting completed access sets it, and a refill clears it.
- R9: rsp_dirty reports the entry's dirty bit before the access. A completed store sets it.
- R10: Refills go into the eight entries in round-robin order starting at entry 0, so the ninth refill evicts the first page written.
- R11: After reset req_ready=1, rsp_valid=0, mem_req=0, xlat_req=0, and the translation buffer and the cache hold nothing valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, can accept |
| req_write | input | 1 | 1 = store, 0 = load |
| req_vaddr | input | 32 | Virtual address |
| req_wdata | input | 32 | Store data |
| rsp_valid | output | 1 | Access completed this cycle |
| rsp_hit | output | 1 | Completed without any fill or refill |
| rsp_fault | output | 1 | Permission violation |
| rsp_rdata | output | 32 | Load data |
| rsp_ref | output | 1 | Reference bit before access |
| rsp_dirty | output | 1 | Dirty bit before access |
| mem_req | output | 1 | Word fetch request |
| mem_paddr | output | 32 | Physical word address |
| mem_fill_valid | input | 1 | Fetched word present |
| mem_fill_data | input | 32 | Fetched word |
| xlat_req | output | 1 | Translation needed |
| xlat_vpn | output | 20 | Page number to translate |
| tlb_wr_en | input | 1 | Refill write |
| tlb_wr_vpn | input | 20 | Refill page number |
| tlb_wr_pfn | input | 20 | Refill frame number |
| tlb_wr_rights | input | 2 | Refill permissions |

## Verification
The bench maps two pages onto one frame and expects the second page to hit on the line the first filled. A design that tagged lines with virtual bits would miss there, or would hit after a different frame took the same index. It issues a store to a load-only page and then reloads, expecting the old word. A design that updated the array before the permission check would return the store data. It writes nine refills and expects the first page to miss while the second still translates, which exposes a wrong pointer start or wrap. It also checks the reference and dirty bits on consecutive accesses to catch bits set one access early or never.

// File: rtl/xlat_cache.sv
module xlat_cache #(
  parameter int VA_W     = 32,
  parameter int OFF_W    = 12,
  parameter int BYTE_W   = 2,
  parameter int DATA_W   = 32,
  parameter int TLB_N    = 8,
  parameter int RIGHTS_W = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic                      req_write,
  input  logic [VA_W-1:0]           req_vaddr,
  input  logic [DATA_W-1:0]         req_wdata,
  output logic                      rsp_valid,
  output logic                      rsp_hit,
  output logic                      rsp_fault,
  output logic [DATA_W-1:0]         rsp_rdata,
  output logic                      rsp_ref,
  output logic                      rsp_dirty,
  output logic                      mem_req,
  output logic [VA_W-1:0]           mem_paddr,
  input  logic                      mem_fill_valid,
  input  logic [DATA_W-1:0]         mem_fill_data,
  output logic                      xlat_req,
  output logic [VA_W-OFF_W-1:0]     xlat_vpn,
  input  logic                      tlb_wr_en,
  input  logic [VA_W-OFF_W-1:0]     tlb_wr_vpn,
  input  logic [VA_W-OFF_W-1:0]     tlb_wr_pfn,
  input  logic [RIGHTS_W-1:0]       tlb_wr_rights
);
  localparam int VPN_W = VA_W - OFF_W;
  localparam int IDX_W = OFF_W - BYTE_W;
  localparam int LINES = 1 << IDX_W;
  localparam int PTR_W = $clog2(TLB_N);

  typedef enum logic [1:0] {S_IDLE, S_LOOK, S_XLAT, S_MEM} state_t;
  state_t state;

  logic              q_write, missed;
  logic [VA_W-1:0]   q_vaddr;
  logic [DATA_W-1:0] q_wdata;

  logic [VPN_W-1:0]    t_vpn   [TLB_N];
  logic [VPN_W-1:0]    t_pfn   [TLB_N];
  logic [RIGHTS_W-1:0] t_rights[TLB_N];
  logic [TLB_N-1:0]    t_valid, t_ref, t_dirty;
  logic [PTR_W-1:0]    rr_ptr;

  logic [DATA_W-1:0] c_data [LINES];
  logic [VPN_W-1:0]  c_tag  [LINES];
  logic [LINES-1:0]  c_valid;

  wire [VPN_W-1:0] vpn = q_vaddr[VA_W-1:OFF_W];
  wire [IDX_W-1:0] idx = q_vaddr[OFF_W-1:BYTE_W];

  logic             tlb_hit;
  logic [PTR_W-1:0] hit_sel;

  always_comb begin
    tlb_hit = 1'b0;
    hit_sel = '0;
    for (int i = TLB_N - 1; i >= 0; i--) begin
      if (t_valid[i] && t_vpn[i] == vpn) begin
        tlb_hit = 1'b1;
        hit_sel = PTR_W'(i);
      end
    end
  end

  wire [VPN_W-1:0] pfn     = t_pfn[hit_sel];
  wire             allowed = q_write ? t_rights[hit_sel][1] : t_rights[hit_sel][0];
  wire             fault   = tlb_hit && !allowed;
  wire             c_hit   = tlb_hit && c_valid[idx] && c_tag[idx] == pfn;
  wire             in_look = state == S_LOOK;
  wire             done_ok = in_look && c_hit && allowed;

  assign req_ready = state == S_IDLE;
  assign rsp_valid = in_look && (fault || c_hit);
  assign rsp_fault = in_look && fault;
  assign rsp_hit   = done_ok && !missed;
  assign rsp_rdata = c_data[idx];
  assign rsp_ref   = t_ref[hit_sel];
  assign rsp_dirty = t_dirty[hit_sel];
  assign mem_req   = state == S_MEM;
  assign mem_paddr = {pfn, idx, {BYTE_W{1'b0}}};
  assign xlat_req  = state == S_XLAT;
  assign xlat_vpn  = vpn;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      missed  <= 1'b0;
      q_write <= 1'b0;
      q_vaddr <= '0;
      q_wdata <= '0;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          state   <= S_LOOK;
          missed  <= 1'b0;
          q_write <= req_write;
          q_vaddr <= req_vaddr;
          q_wdata <= req_wdata;
        end
        S_LOOK: begin
          if (!tlb_hit) begin
            state  <= S_XLAT;
            missed <= 1'b1;
          end else if (fault || c_hit) begin
            state <= S_IDLE;
          end else begin
            state  <= S_MEM;
            missed <= 1'b1;
          end
        end
        S_XLAT: if (tlb_wr_en) state <= S_LOOK;
        S_MEM:  if (mem_fill_valid) state <= S_LOOK;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rr_ptr  <= '0;
      t_valid <= '0;
      t_ref   <= '0;
      t_dirty <= '0;
      for (int i = 0; i < TLB_N; i++) begin
        t_vpn[i]    <= '0;
        t_pfn[i]    <= '0;
        t_rights[i] <= '0;
      end
    end else begin
      if (done_ok) begin
        t_ref[hit_sel] <= 1'b1;
        if (q_write) t_dirty[hit_sel] <= 1'b1;
      end
      if (tlb_wr_en) begin
        t_vpn[rr_ptr]    <= tlb_wr_vpn;
        t_pfn[rr_ptr]    <= tlb_wr_pfn;
        t_rights[rr_ptr] <= tlb_wr_rights;
        t_valid[rr_ptr]  <= 1'b1;
        t_ref[rr_ptr]    <= 1'b0;
        t_dirty[rr_ptr]  <= 1'b0;
        rr_ptr           <= (rr_ptr == PTR_W'(TLB_N - 1)) ? '0 : rr_ptr + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) c_valid <= '0;
    else if (state == S_MEM && mem_fill_valid) c_valid[idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (state == S_MEM && mem_fill_valid) begin
      c_data[idx] <= mem_fill_data;
      c_tag[idx]  <= pfn;
    end else if (done_ok && q_write) begin
      c_data[idx] <= q_wdata;
    end
  end

  a_r3_xlat_hold: assert property (@(posedge clk) disable iff (!rst_n)
    xlat_req && !tlb_wr_en |=> xlat_req && $stable(xlat_vpn));
  a_r4_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_fill_valid && !tlb_wr_en |=> mem_req && $stable(mem_paddr));
  a_r4_fill_retry: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_fill_valid && !tlb_wr_en |=> rsp_valid && !rsp_hit && !rsp_fault);
  a_r7_fault_excl: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !(rsp_fault && rsp_hit));
  a_r2_ready_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req && !xlat_req && !rsp_valid);
  a_r11_reset_idle: assert property (@(posedge clk)
    $rose(rst_n) |-> req_ready);
endmodule

// File: tb/xlat_cache_tb.sv
module xlat_cache_tb_top;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_ready, req_write = 0;
  logic [31:0] req_vaddr = 0, req_wdata = 0;
  logic rsp_valid, rsp_hit, rsp_fault, rsp_ref, rsp_dirty;
  logic [31:0] rsp_rdata, mem_paddr;
  logic mem_req, mem_fill_valid = 0;
  logic [31:0] mem_fill_data = 0;
  logic xlat_req;
  logic [19:0] xlat_vpn;
  logic tlb_wr_en = 0;
  logic [19:0] tlb_wr_vpn = 0, tlb_wr_pfn = 0;
  logic [1:0] tlb_wr_rights = 0;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  xlat_cache dut_i (.*);

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic wr, input logic [31:0] va, input logic [31:0] wd);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = wr; req_vaddr = va; req_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic wait_evt(output logic ok);
    ok = 0;
    for (int i = 0; i < 100; i++) begin
      if (rsp_valid || mem_req || xlat_req) begin ok = 1; break; end
      @(negedge clk);
    end
    if (!ok) check(0, "watchdog", 0, 1);
  endtask

  task automatic refill(input logic [19:0] v, input logic [19:0] p, input logic [1:0] r);
    @(negedge clk);
    tlb_wr_en = 1; tlb_wr_vpn = v; tlb_wr_pfn = p; tlb_wr_rights = r;
    @(negedge clk);
    tlb_wr_en = 0;
  endtask

  task automatic fill(input logic [31:0] d);
    @(negedge clk);
    mem_fill_valid = 1; mem_fill_data = d;
    @(negedge clk);
    mem_fill_valid = 0;
  endtask

  task automatic t_reset;
    check(req_ready === 1, "R11 ready", req_ready, 1);
    check(!rsp_valid && !mem_req && !xlat_req, "R11 quiet", {rsp_valid, mem_req, xlat_req}, 0);
  endtask

  task automatic t_cold;
    logic ok;
    issue(0, 32'h12345678, 0);
    wait_evt(ok);
    check(xlat_req && xlat_vpn == 20'h12345, "R3 xlat vpn", xlat_vpn, 32'h12345);
    refill(20'h12345, 20'h00ABC, 2'b11);
    wait_evt(ok);
    check(mem_req && mem_paddr == 32'h00ABC678, "R1 R4 paddr", mem_paddr, 32'h00ABC678);
    fill(32'hD1D1D1D1);
    wait_evt(ok);
    check(rsp_valid && !rsp_hit && rsp_rdata == 32'hD1D1D1D1, "R4 filled", rsp_rdata, 32'hD1D1D1D1);
    check(rsp_ref == 0, "R8 ref fresh", rsp_ref, 0);
  endtask

  task automatic t_hit;
    logic ok;
    issue(0, 32'h12345679, 0);
    wait_evt(ok);
    check(rsp_valid && rsp_hit && rsp_rdata == 32'hD1D1D1D1, "R2 R1 hit", rsp_rdata, 32'hD1D1D1D1);
    check(rsp_ref == 1, "R8 ref set", rsp_ref, 1);
  endtask

  task automatic t_write;
    logic ok;
    issue(1, 32'h12345678, 32'hD2D2D2D2);
    wait_evt(ok);
    check(rsp_valid && rsp_hit && rsp_dirty == 0, "R9 clean before", rsp_dirty, 0);
    issue(0, 32'h12345678, 0);
    wait_evt(ok);
    check(rsp_valid && rsp_rdata == 32'hD2D2D2D2, "R6 write data", rsp_rdata, 32'hD2D2D2D2);
    check(rsp_dirty == 1, "R9 dirty", rsp_dirty, 1);
  endtask

  task automatic t_alias;
    logic ok;
    refill(20'h55555, 20'h00ABC, 2'b11);
    issue(0, 32'h55555678, 0);
    wait_evt(ok);
    check(rsp_valid && rsp_hit && rsp_rdata == 32'hD2D2D2D2, "R5 alias hit", rsp_rdata, 32'hD2D2D2D2);
    refill(20'h66666, 20'h00DEF, 2'b11);
    issue(0, 32'h66666678, 0);
    wait_evt(ok);
    check(mem_req && mem_paddr == 32'h00DEF678, "R5 other frame miss", mem_paddr, 32'h00DEF678);
    fill(32'hD3D3D3D3);
    wait_evt(ok);
    check(rsp_valid && rsp_rdata == 32'hD3D3D3D3, "R4 fill 2", rsp_rdata, 32'hD3D3D3D3);
    issue(0, 32'h12345678, 0);
    wait_evt(ok);
    check(mem_req && mem_paddr == 32'h00ABC678, "R5 evicted", mem_paddr, 32'h00ABC678);
    fill(32'hD1D1D1D1);
    wait_evt(ok);
  endtask

  task automatic t_rights;
    logic ok;
    refill(20'h77777, 20'h00111, 2'b01);
    issue(0, 32'h77777100, 0);
    wait_evt(ok);
    check(mem_req, "R7 read ok", mem_req, 1);
    fill(32'hD4D4D4D4);
    wait_evt(ok);
    issue(1, 32'h77777100, 32'hD5D5D5D5);
    wait_evt(ok);
    check(rsp_valid && rsp_fault && !rsp_hit && !mem_req, "R7 write fault", {rsp_fault, rsp_hit}, 2'b10);
    issue(0, 32'h77777100, 0);
    wait_evt(ok);
    check(rsp_valid && rsp_hit && rsp_rdata == 32'hD4D4D4D4, "R7 unchanged", rsp_rdata, 32'hD4D4D4D4);
    check(rsp_dirty == 0, "R7 R9 no dirty", rsp_dirty, 0);
    refill(20'h88888, 20'h00222, 2'b10);
    issue(0, 32'h88888200, 0);
    wait_evt(ok);
    check(rsp_valid && rsp_fault, "R7 read fault", rsp_fault, 1);
  endtask

  task automatic t_rr;
    logic ok;
    refill(20'h90001, 20'h00301, 2'b11);
    refill(20'h90002, 20'h00302, 2'b11);
    refill(20'h90003, 20'h00303, 2'b11);
    refill(20'h9A000, 20'h00400, 2'b11);
    issue(0, 32'h55555678, 0);
    wait_evt(ok);
    check(!xlat_req, "R10 second kept", xlat_req, 0);
    if (mem_req) begin fill(32'h0); wait_evt(ok); end
    issue(0, 32'h12345678, 0);
    wait_evt(ok);
    check(xlat_req && xlat_vpn == 20'h12345, "R10 first evicted", xlat_req, 1);
    refill(20'h12345, 20'h00ABC, 2'b11);
    wait_evt(ok);
    if (mem_req) begin fill(32'h0); wait_evt(ok); end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_cold();
    t_hit();
    t_write();
    t_alias();
    t_rights();
    t_rr();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule